// File: doc/BRIEF.md
# Size-Aware Integer Execute Unit

This block carries out the data step of a small integer instruction group: register-to-destination move, add-immediate, quick add, two-operand add (including the add-to-address-register forms) and 16- and 32-bit multiplies, both signed and unsigned. Operand fetch and write-back addressing are done elsewhere. The unit receives a decoded operation code, a size code and the relevant opcode and extension fields. It also receives two operands that are already fetched: the effective-address operand and the register or immediate operand. One clock later it returns the destination value, merged to the operation size. Along with that value it returns where the value goes, an optional second register write for the upper half of a 64-bit product, and the N, Z, V, C condition flags.

A destination of byte or word size keeps the upper bits of its previous content. The old content is taken from whichever operand stands for the destination. The sequencer reads the destination class and register number to steer the write-back. It reads the extra-length output to step past a long multiply's extension word.

Top module: `xu_exec`

## Requirements
- R1: Every accepted operation (in_valid high with in_op 0 to 5) raises out_valid exactly one clock later. Operation codes 6 and 7 raise no out_valid and change no flag. Reset forces out_valid, out_hi_we and all four flags to 0.
- R2: Size codes are 00 byte, 01 word, 10 long, and 11 also means long. A byte result replaces only bits 7:0 of the old destination value, a word result only bits 15:0, and a long result all 32 bits.
- R3: Move (in_op 0) uses in_size. It returns in_opa merged into in_opb, with class 2 (effective address). N is set to the operand's sign bit at that size (bit 7, 15 or 31). Z is set when the operand's bits at that size are all zero. V and C are cleared.
- R4: Any operation other than move leaves N, Z, V and C unchanged.
- R5: Add-immediate (in_op 1) returns in_opa + in_opb at the size in in_opmode[1:0], merged into in_opa, with class 2.
- R6: Quick add (in_op 2) adds the value in in_regfld (opcode bits 11:9) to in_opa, with a field value of 0 standing for 8. The size is in_opmode[1:0], the merge is into in_opa, and the class is 2.
- R7: Add (in_op 3) with in_opmode[2]=0 (opcode bit 8 clear) writes the sum into data register in_regfld (class 0), merged into in_opb. With in_opmode[2]=1 it writes the sum to the effective address (class 2), merged into in_opa. The size is in_opmode[1:0].
- R8: Add with in_opmode 3 writes a word sum, and add with in_opmode 7 a long sum, into address register in_regfld (class 1), merged into in_opb.
- R9: A word multiply (in_op 4 unsigned or 5 signed, in_size not 10) extends bits 15:0 of both operands to 32 bits. It writes the full 32-bit product to data register in_regfld, and out_ext_len is 0.
- R10: A long multiply (in_size 10) writes the low 32 product bits to data register in_ext_lo_reg (extension bits 14:12), and out_ext_len is 2. When in_ext_hi_en (extension bit 10) is set, out_hi_we is raised and the high 32 bits go to register in_ext_hi_reg (extension bits 2:0). Otherwise out_hi_we stays 0.
- R11: The signed multiply treats both operands as two's complement, and the unsigned multiply treats both as unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | 0 move, 1 add-immediate, 2 quick add, 3 add, 4 unsigned multiply, 5 signed multiply |
| in_size | input | 2 | Size code for move and multiply |
| in_regfld | input | 3 | Opcode bits 11:9 (register number or quick value) |
| in_opmode | input | 3 | Opcode bits 8:6 (direction bit and size / opmode) |
| in_ext_lo_reg | input | 3 | Extension bits 14:12, long multiply low register |
| in_ext_hi_en | input | 1 | Extension bit 10, request high product write |
| in_ext_hi_reg | input | 3 | Extension bits 2:0, long multiply high register |
| in_opa | input | 32 | Effective-address operand |
| in_opb | input | 32 | Register or immediate operand |
| out_valid | output | 1 | Result present |
| out_res | output | 32 | Merged destination value |
| out_kind | output | 2 | Destination class: 0 data reg, 1 address reg, 2 effective address |
| out_reg | output | 3 | Register number for classes 0 and 1, else 0 |
| out_ext_len | output | 3 | Extra instruction length in bytes |
| out_hi_we | output | 1 | Second register write for the high product |
| out_hi_reg | output | 3 | Register for the high product |
| out_hi | output | 32 | High 32 product bits |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
A long multiply with the high-half request produces two register writes in the same result cycle: the low word in out_res and the upper word on out_hi. The bench issues signed and unsigned long products whose halves differ. It judges both writes and both register numbers against a 64-bit product computed independently, and it also sends a request with the high write disabled. A second overlap is a flag update landing in the cycle after non-move results. The bench runs move and add operations back to back and checks that the flags keep the last move's values.

// File: rtl/xu_pkg.sv
package xu_pkg;
  typedef enum logic [2:0] {
    OP_MOVE = 3'd0,
    OP_ADDI = 3'd1,
    OP_ADDQ = 3'd2,
    OP_ADD  = 3'd3,
    OP_MULU = 3'd4,
    OP_MULS = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    DK_DATA = 2'd0,
    DK_ADDR = 2'd1,
    DK_EA   = 2'd2
  } dkind_e;

  typedef enum logic [1:0] {
    AS_PASS = 2'd0,
    AS_OPB  = 2'd1,
    AS_QUICK = 2'd2,
    AS_MUL  = 2'd3
  } asel_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;
endpackage

// File: rtl/xu_decode.sv
module xu_decode
  import xu_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] op,
  input  logic [1:0] size,
  input  logic [2:0] regfld,
  input  logic [2:0] opmode,
  input  logic [2:0] ext_lo_reg,
  input  logic       ext_hi_en,
  input  logic [2:0] ext_hi_reg,
  output logic       legal,
  output logic [1:0] msz,
  output dkind_e     kind,
  output logic [2:0] dreg,
  output logic       old_is_b,
  output asel_e      asel,
  output logic [3:0] quick,
  output logic       flag_en,
  output logic       mul_signed,
  output logic       mul_long,
  output logic       hi_we,
  output logic [2:0] hi_reg,
  output logic [2:0] ext_len
);
  always_comb begin
    legal      = 1'b1;
    msz        = opmode[1:0];
    kind       = DK_EA;
    dreg       = 3'd0;
    old_is_b   = 1'b0;
    asel       = AS_PASS;
    flag_en    = 1'b0;
    mul_signed = 1'b0;
    mul_long   = 1'b0;
    hi_we      = 1'b0;
    hi_reg     = ext_hi_reg;
    ext_len    = 3'd0;
    quick      = (regfld == 3'd0) ? 4'd8 : {1'b0, regfld};
    unique case (op)
      OP_MOVE: begin
        msz      = size;
        old_is_b = 1'b1;
        flag_en  = valid;
      end
      OP_ADDI: asel = AS_OPB;
      OP_ADDQ: asel = AS_QUICK;
      OP_ADD: begin
        asel = AS_OPB;
        if (opmode[1:0] == 2'b11) begin
          kind     = DK_ADDR;
          dreg     = regfld;
          old_is_b = 1'b1;
          msz      = opmode[2] ? SZ_LONG : SZ_WORD;
        end else if (!opmode[2]) begin
          kind     = DK_DATA;
          dreg     = regfld;
          old_is_b = 1'b1;
        end
      end
      OP_MULU, OP_MULS: begin
        asel       = AS_MUL;
        msz        = SZ_LONG;
        kind       = DK_DATA;
        mul_signed = (op == OP_MULS);
        mul_long   = (size == SZ_LONG);
        dreg       = mul_long ? ext_lo_reg : regfld;
        hi_we      = mul_long && ext_hi_en && valid;
        ext_len    = mul_long ? 3'd2 : 3'd0;
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/xu_merge.sv
module xu_merge
  import xu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    msz,
  input  logic [DW-1:0] new_val,
  input  logic [DW-1:0] old_val,
  output logic [DW-1:0] merged
);
  localparam int LANES = DW / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic take_new;
    always_comb begin
      take_new = (i == 0) || msz[1] || ((i == 1) && (msz == SZ_WORD));
      merged[8*i +: 8] = take_new ? new_val[8*i +: 8] : old_val[8*i +: 8];
    end
  end
endmodule

// File: rtl/xu_mul.sv
module xu_mul #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            is_signed,
  input  logic            is_long,
  output logic [2*DW-1:0] prod
);
  localparam int HW = 16;

  logic [DW-1:0]   a_w, b_w;
  logic [2*DW-1:0] a_x, b_x;

  always_comb begin
    if (is_long) begin
      a_w = a;
      b_w = b;
    end else begin
      a_w = {{(DW-HW){is_signed & a[HW-1]}}, a[HW-1:0]};
      b_w = {{(DW-HW){is_signed & b[HW-1]}}, b[HW-1:0]};
    end
    a_x  = {{DW{is_signed & a_w[DW-1]}}, a_w};
    b_x  = {{DW{is_signed & b_w[DW-1]}}, b_w};
    prod = a_x * b_x;
  end
endmodule

// File: rtl/xu_exec.sv
module xu_exec
  import xu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    in_op,
  input  logic [1:0]    in_size,
  input  logic [2:0]    in_regfld,
  input  logic [2:0]    in_opmode,
  input  logic [2:0]    in_ext_lo_reg,
  input  logic          in_ext_hi_en,
  input  logic [2:0]    in_ext_hi_reg,
  input  logic [DW-1:0] in_opa,
  input  logic [DW-1:0] in_opb,
  output logic          out_valid,
  output logic [DW-1:0] out_res,
  output logic [1:0]    out_kind,
  output logic [2:0]    out_reg,
  output logic [2:0]    out_ext_len,
  output logic          out_hi_we,
  output logic [2:0]    out_hi_reg,
  output logic [DW-1:0] out_hi,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v,
  output logic          flag_c
);
  logic          legal, old_is_b, flag_en, mul_signed, mul_long, hi_we;
  logic [1:0]    msz;
  dkind_e        kind;
  asel_e         asel;
  logic [2:0]    dreg, hi_reg, ext_len;
  logic [3:0]    quick;
  logic [2*DW-1:0] prod;
  logic [DW-1:0] raw, old_val, merged;
  logic          accept, nxt_n, nxt_z;

  xu_decode u_dec (
    .valid(in_valid), .op(in_op), .size(in_size), .regfld(in_regfld),
    .opmode(in_opmode), .ext_lo_reg(in_ext_lo_reg), .ext_hi_en(in_ext_hi_en),
    .ext_hi_reg(in_ext_hi_reg), .legal(legal), .msz(msz), .kind(kind),
    .dreg(dreg), .old_is_b(old_is_b), .asel(asel), .quick(quick),
    .flag_en(flag_en), .mul_signed(mul_signed), .mul_long(mul_long),
    .hi_we(hi_we), .hi_reg(hi_reg), .ext_len(ext_len)
  );

  xu_mul #(.DW(DW)) u_mul (
    .a(in_opa), .b(in_opb), .is_signed(mul_signed), .is_long(mul_long),
    .prod(prod)
  );

  always_comb begin
    unique case (asel)
      AS_OPB:   raw = in_opa + in_opb;
      AS_QUICK: raw = in_opa + DW'(quick);
      AS_MUL:   raw = prod[DW-1:0];
      default:  raw = in_opa;
    endcase
    old_val = old_is_b ? in_opb : in_opa;
  end

  xu_merge #(.DW(DW)) u_merge (
    .msz(msz), .new_val(raw), .old_val(old_val), .merged(merged)
  );

  // flag next state for a move, evaluated at the move's size
  always_comb begin
    unique case (msz)
      SZ_BYTE: begin nxt_n = in_opa[7];    nxt_z = (in_opa[7:0] == 8'd0);   end
      SZ_WORD: begin nxt_n = in_opa[15];   nxt_z = (in_opa[15:0] == 16'd0); end
      default: begin nxt_n = in_opa[DW-1]; nxt_z = (in_opa == '0);          end
    endcase
  end

  assign accept = in_valid && legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hi_we <= 1'b0;
    end else begin
      out_valid <= accept;
      out_hi_we <= accept && hi_we;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_res     <= merged;
      out_kind    <= kind;
      out_reg     <= dreg;
      out_ext_len <= ext_len;
      out_hi_reg  <= hi_reg;
      out_hi      <= prod[2*DW-1:DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
      flag_c <= 1'b0;
    end else if (accept && flag_en) begin
      flag_n <= nxt_n;
      flag_z <= nxt_z;
      flag_v <= 1'b0;
      flag_c <= 1'b0;
    end
  end

  // R1: accepted operation produces a result one clock later
  a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op <= 3'd5) |=> out_valid);
  a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || in_op > 3'd5) |=> !out_valid);
  // R3: a move clears overflow and carry
  a_r3_move_vc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd0) |=> (!flag_v && !flag_c));
  // R4: flags hold across non-move cycles
  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_op == 3'd0) |=> $stable({flag_n, flag_z, flag_v, flag_c}));
  // R2: byte quick add keeps the upper destination bits
  a_r2_byte_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd2 && in_opmode[1:0] == 2'b00)
      |=> out_res[DW-1:8] == $past(in_opa[DW-1:8]));
  // R6: quick add at long size always changes the operand
  a_r6_quick_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd2 && in_opmode[1:0] == 2'b10)
      |=> out_res != $past(in_opa));
  // R10: second write only for long multiply with the request bit
  a_r10_hi_only_long: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(in_op[2:1] == 2'b10 && in_size == 2'b10 && in_ext_hi_en))
      |=> !out_hi_we);
  a_r10_len: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[2:1] == 2'b10 && in_size == 2'b10) |=> out_ext_len == 3'd2);
endmodule

// File: tb/xu_exec_test.sv
module xu_exec_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, in_valid, in_ext_hi_en;
  logic [2:0]  in_op, in_regfld, in_opmode, in_ext_lo_reg, in_ext_hi_reg;
  logic [1:0]  in_size;
  logic [31:0] in_opa, in_opb;
  logic        out_valid, out_hi_we, flag_n, flag_z, flag_v, flag_c;
  logic [31:0] out_res, out_hi;
  logic [1:0]  out_kind;
  logic [2:0]  out_reg, out_ext_len, out_hi_reg;

  xu_exec uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_size(in_size), .in_regfld(in_regfld), .in_opmode(in_opmode),
    .in_ext_lo_reg(in_ext_lo_reg), .in_ext_hi_en(in_ext_hi_en),
    .in_ext_hi_reg(in_ext_hi_reg), .in_opa(in_opa), .in_opb(in_opb),
    .out_valid(out_valid), .out_res(out_res), .out_kind(out_kind),
    .out_reg(out_reg), .out_ext_len(out_ext_len), .out_hi_we(out_hi_we),
    .out_hi_reg(out_hi_reg), .out_hi(out_hi), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  typedef struct {
    string       req;
    logic [31:0] res;
    logic [1:0]  kind;
    logic [2:0]  rg;
    logic [2:0]  elen;
    logic        hwe;
    logic [2:0]  hreg;
    logic [31:0] hi;
    logic [3:0]  fl;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  logic [3:0] m_fl;
  bit   done = 0;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mrg(logic [1:0] sz, logic [31:0] nv, logic [31:0] ov);
    case (sz)
      2'b00:   return {ov[31:8], nv[7:0]};
      2'b01:   return {ov[31:16], nv[15:0]};
      default: return nv;
    endcase
  endfunction

  task automatic issue(string req, logic [2:0] op, logic [1:0] sz, logic [2:0] rf,
                       logic [2:0] om, logic [2:0] elo, logic ehe, logic [2:0] ehr,
                       logic [31:0] a, logic [31:0] b);
    exp_t e;
    logic [1:0] s;
    logic [63:0] p;
    logic [31:0] q;
    @(negedge clk);
    in_valid = 1; in_op = op; in_size = sz; in_regfld = rf; in_opmode = om;
    in_ext_lo_reg = elo; in_ext_hi_en = ehe; in_ext_hi_reg = ehr;
    in_opa = a; in_opb = b;
    e.req = req; e.kind = 2'd2; e.rg = 0; e.elen = 0; e.hwe = 0; e.hreg = ehr; e.hi = 0;
    s = om[1:0];
    case (op)
      3'd0: begin
        e.res = mrg(sz, a, b);
        case (sz)
          2'b00:   m_fl = {a[7],  a[7:0] == 0, 2'b00};
          2'b01:   m_fl = {a[15], a[15:0] == 0, 2'b00};
          default: m_fl = {a[31], a == 0, 2'b00};
        endcase
      end
      3'd1: e.res = mrg(s, a + b, a);
      3'd2: begin q = (rf == 0) ? 32'd8 : {29'd0, rf}; e.res = mrg(s, a + q, a); end
      3'd3: begin
        if (s == 2'b11) begin
          e.kind = 1; e.rg = rf; e.res = mrg(om[2] ? 2'b10 : 2'b01, a + b, b);
        end else if (!om[2]) begin
          e.kind = 0; e.rg = rf; e.res = mrg(s, a + b, b);
        end else e.res = mrg(s, a + b, a);
      end
      default: begin
        e.kind = 0;
        if (sz == 2'b10) begin
          if (op == 3'd5) p = 64'(longint'($signed(a)) * longint'($signed(b)));
          else            p = {32'd0, a} * {32'd0, b};
          e.rg = elo; e.elen = 2; e.hwe = ehe; e.hi = p[63:32];
        end else begin
          if (op == 3'd5) p = 64'(longint'($signed(a[15:0])) * longint'($signed(b[15:0])));
          else            p = {48'd0, a[15:0]} * {48'd0, b[15:0]};
          e.rg = rf; e.hi = p[63:32];
        end
        e.res = p[31:0];
      end
    endcase
    e.fl = m_fl;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  // monitor: compares each result against the oldest expected item
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fails++;
        $display("FAIL R1 unexpected result: actual out_valid=1 expected 0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (out_res !== e.res || out_kind !== e.kind || out_reg !== e.rg ||
            out_ext_len !== e.elen || out_hi_we !== e.hwe ||
            (e.hwe && (out_hi !== e.hi || out_hi_reg !== e.hreg)) ||
            {flag_n, flag_z, flag_v, flag_c} !== e.fl) begin
          n_fails++;
          $display("FAIL %s actual res=%h kind=%0d reg=%0d len=%0d hwe=%b hreg=%0d hi=%h fl=%b expected res=%h kind=%0d reg=%0d len=%0d hwe=%b hreg=%0d hi=%h fl=%b",
                   e.req, out_res, out_kind, out_reg, out_ext_len, out_hi_we, out_hi_reg,
                   out_hi, {flag_n, flag_z, flag_v, flag_c}, e.res, e.kind, e.rg, e.elen,
                   e.hwe, e.hreg, e.hi, e.fl);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    m_fl = 4'b0000;
    rst_n = 0; in_valid = 0; in_op = 0; in_size = 0; in_regfld = 0; in_opmode = 0;
    in_ext_lo_reg = 0; in_ext_hi_en = 0; in_ext_hi_reg = 0; in_opa = 0; in_opb = 0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 0 || out_hi_we !== 0 || {flag_n, flag_z, flag_v, flag_c} !== 4'b0000) begin
      n_fails++;
      $display("FAIL R1 reset: actual v=%b hwe=%b fl=%b expected 0 0 0000",
               out_valid, out_hi_we, {flag_n, flag_z, flag_v, flag_c});
    end
    rst_n = 1;
    @(negedge clk);
    // R3 moves at each size
    issue("R3 move byte negative", 0, 2'b00, 0, 0, 0, 0, 0, 32'h0000_0080, 32'hAABB_CCDD);
    issue("R3 move word zero", 0, 2'b01, 0, 0, 0, 0, 0, 32'h1234_0000, 32'hFFFF_FFFF);
    issue("R3 move long positive", 0, 2'b10, 0, 0, 0, 0, 0, 32'h7FFF_FFFF, 32'h0);
    // R5 / R2 / R4 add-immediate byte wrap keeps upper bits, flags held
    issue("R5 R2 R4 addi byte wrap", 1, 2'b00, 0, 3'b000, 0, 0, 0, 32'h5566_77FF, 32'h0000_0001);
    issue("R5 addi word", 1, 2'b00, 0, 3'b001, 0, 0, 0, 32'hAAAA_FFF0, 32'h0000_0020);
    // R6 quick add
    issue("R6 addq zero means 8", 2, 2'b00, 3'd0, 3'b001, 0, 0, 0, 32'h0101_FFFC, 32'h0);
    issue("R6 addq 7 long", 2, 2'b00, 3'd7, 3'b010, 0, 0, 0, 32'h0000_FFFF, 32'h0);
    issue("R6 R2 addq byte", 2, 2'b00, 3'd3, 3'b000, 0, 0, 0, 32'hDEAD_BEFE, 32'h0);
    // R7 add direction
    issue("R7 add to data reg", 3, 2'b00, 3'd5, 3'b001, 0, 0, 0, 32'h0000_1111, 32'h9999_2222);
    issue("R7 add to ea", 3, 2'b00, 3'd5, 3'b100, 0, 0, 0, 32'h8888_8810, 32'h7777_7720);
    // R8 address-register forms
    issue("R8 add addr word", 3, 2'b00, 3'd2, 3'b011, 0, 0, 0, 32'hFFFF_8000, 32'h1234_9000);
    issue("R8 add addr long", 3, 2'b00, 3'd6, 3'b111, 0, 0, 0, 32'hFFFF_8000, 32'h1234_9000);
    // R9 / R11 word multiplies
    issue("R9 R11 mulu word", 4, 2'b01, 3'd1, 0, 0, 1, 0, 32'h1234_FFFF, 32'h5678_FFFF);
    issue("R9 R11 muls word", 5, 2'b01, 3'd4, 0, 0, 1, 0, 32'h0000_FFFF, 32'h0000_8000);
    // R10 / R11 long multiplies
    issue("R10 R11 mulu long hi", 4, 2'b10, 3'd1, 0, 3'd3, 1, 3'd6, 32'hFFFF_FFFF, 32'h0000_0002);
    issue("R10 R11 muls long hi", 5, 2'b10, 3'd1, 0, 3'd7, 1, 3'd2, 32'hFFFF_FFFF, 32'h0000_0002);
    issue("R10 long no hi", 5, 2'b10, 3'd1, 0, 3'd0, 0, 3'd5, 32'h8000_0000, 32'h8000_0000);
    issue("R3 move byte zero", 0, 2'b00, 0, 0, 0, 0, 0, 32'hFFFF_FF00, 32'h0);
    issue("R4 flags after move", 1, 2'b00, 0, 3'b010, 0, 0, 0, 32'h1, 32'h1);
    // R1 illegal operation: no result, flags untouched
    @(negedge clk);
    in_valid = 1; in_op = 3'd6; in_opa = 32'h0000_0080; in_size = 2'b00;
    idle();
    n_checks++;
    if (out_valid !== 0) begin
      n_fails++;
      $display("FAIL R1 illegal op: actual out_valid=%b expected 0", out_valid);
    end
    issue("R1 R4 flags after illegal", 1, 2'b00, 0, 3'b010, 0, 0, 0, 32'h2, 32'h3);
    idle();
    repeat (3) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fails++;
      $display("FAIL R1 missing results: actual pending=%0d expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule